// File: doc/BRIEF.md
# Descriptor-Chained XOR and Fill Engine

This block is a memory-to-memory engine that walks a linked list of descriptors stored in system memory. Each descriptor names up to eight source regions, one destination region, a byte count and a command word. For every 32-bit word position, the engine folds the sources into an accumulator and then writes the result to the destination. A per-source command code controls the fold: it can skip the source, load the accumulator from it, or XOR the source into the accumulator. The first source can instead supply an immediate pattern, which makes the descriptor a fill. With these codes a single chain can zero or pattern-fill a buffer, copy a buffer, or compute an N-way parity block.

Software writes the address of the first descriptor into the next-descriptor register and then sets the enable bit. The engine fetches each descriptor, processes its words one at a time, and follows the link until it reaches a link of zero. Completion and errors are reported through sticky status flags and a level interrupt. Software clears these by writing the status value back. Memory is reached through a single-word valid/ready port with an error response.

Top module: `xor_chain_engine`

## Requirements
- R1: After reset, the control register reads 0, the next-descriptor register reads 0, the status register reads 0, `irq` is low and `mem_req` is low.
- R2: Writing 1 to bit 0 of the control register (address 0) starts the engine, provided the next-descriptor register (address 1) is nonzero. The engine then fetches the descriptor at that address with its low 5 bits forced to zero. Descriptor word k sits at byte offset 4k, as follows: word 0 is the link, words 1 to 4 are sources 1 to 4, word 5 is the destination, word 6 is the byte count, word 7 is the command, and words 8 to 11 are sources 5 to 8. Starting with a zero address does nothing.
- R3: Command bits [3i+2:3i] hold the code for source i+1. Code 0 skips the source, code 1 loads the accumulator, and code 2 XORs into the accumulator. Sources are applied in order from 1 to 8. Each destination word w receives the fold of the source words at source address + 4w.
- R4: Sources 5 to 8 take part only when command bit 24 is set. When bit 24 is clear, their codes are ignored.
- R5: Code 3 on source 1 places the source-1 address field itself into the accumulator, so every destination word receives that 32-bit value. A value of 0 zeroes the region.
- R6: A descriptor writes exactly count/4 words, at the destination address, then +4, +8, and so on. The word after the last one is left untouched. A byte count of 0 writes nothing.
- R7: When command bit 25 is clear, the descriptor performs no memory writes but still completes normally.
- R8: A nonzero link makes the engine load it into the next-descriptor register and continue from it. A zero link ends the chain. Status bit 0 (active) is 1 while the engine is working and 0 after the chain ends.
- R9: When a descriptor that has command bit 26 set completes, the engine sets status bit 1 if that descriptor's link is zero. If the link is nonzero, it sets status bit 2 instead.
- R10: An error response to any read or write sets status bit 3, clears the enable bit and halts the engine. No further requests follow.
- R11: `irq` is high exactly while any of status bits 1 to 3 is set. Writing a status value back clears every flag whose bit is 1 in the written data.
- R12: Writing 0 to the control register halts the engine in the next cycle. The active flag clears, no further requests are issued, and no flag is raised.
- R13: Every request is word-aligned and holds its address, direction and data stable until `mem_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 next descriptor, 2 status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt, any sticky flag set |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |

## Verification
The assertions check the following properties on every cycle:
- The memory request is held stable and word-aligned while the engine waits for `mem_ready`.
- No request is issued while the engine is idle.
- A write is issued only when the descriptor allows it.
- An error response or a stop write leaves the engine idle, and an error also sets the abort flag.
- The interrupt stays asserted until software clears it.

Only the bench's scenarios can show that the data is correct. They sweep every source count from one to eight, with and without memory stalls, and cover several other cases:
- immediate and zero fills;
- ignored extended sources;
- exact word counts;
- chains that mix per-descriptor and end-of-chain flags;
- a truncated transfer after an error.

// File: rtl/xor_chain_engine.sv
module xor_chain_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MAX_SRC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err
);
  localparam int HALF  = MAX_SRC / 2;
  localparam int BASEW = HALF + 4;
  localparam int TOTW  = BASEW + HALF;
  localparam int FIW   = $clog2(TOTW);
  localparam int SLW   = $clog2(MAX_SRC);
  localparam int CW    = 3;
  localparam int XB    = CW * MAX_SRC;
  localparam int WB    = XB + 1;
  localparam int IB    = XB + 2;
  localparam int AB    = 5;

  localparam logic [FIW-1:0] F_S1   = FIW'(1);
  localparam logic [FIW-1:0] F_SH   = FIW'(HALF);
  localparam logic [FIW-1:0] F_DST  = FIW'(HALF + 1);
  localparam logic [FIW-1:0] F_CNT  = FIW'(HALF + 2);
  localparam logic [FIW-1:0] F_CMD  = FIW'(HALF + 3);
  localparam logic [FIW-1:0] F_XOFF = FIW'(BASEW - HALF);
  localparam logic [FIW-1:0] F_END  = FIW'(TOTW - 1);
  localparam logic [SLW-1:0] SL_LO  = SLW'(HALF - 1);
  localparam logic [SLW-1:0] SL_HI  = SLW'(MAX_SRC - 1);

  localparam logic [CW-1:0] C_LOAD = 3'd1;
  localparam logic [CW-1:0] C_XOR  = 3'd2;
  localparam logic [CW-1:0] C_IMM  = 3'd3;

  localparam logic [1:0] R_CTRL = 2'd0;
  localparam logic [1:0] R_NDA  = 2'd1;
  localparam logic [1:0] R_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SRC, S_WRITE} state_t;

  state_t        st;
  logic          en, f_eoc, f_eot, f_abort;
  logic [AW-1:0] nda, nxt, dst, cnt, off;
  logic [AW-1:0] src [MAX_SRC];
  logic [DW-1:0] cmd, acc;
  logic [FIW-1:0] fidx;
  logic [SLW-1:0] slot;

  logic          busy, dwe, ext, rd_src, hs, fetch_last, fetch_done, wr_step, desc_end;
  logic          ctrl_wr, stop, go;
  logic [CW-1:0] code;
  logic [SLW-1:0] last_slot;
  logic [AW-3:0] words_left;
  logic [DW-1:0] cmd_now;
  logic [AW-1:0] desc_base;

  assign busy       = (st != S_IDLE);
  assign code       = cmd[slot*CW +: CW];
  assign ext        = cmd[XB];
  assign dwe        = cmd[WB];
  assign last_slot  = ext ? SL_HI : SL_LO;
  assign rd_src     = (code == C_LOAD) || (code == C_XOR);
  assign words_left = cnt[AW-1:2];
  assign ctrl_wr    = reg_wr && (reg_addr == R_CTRL);
  assign stop       = ctrl_wr && !reg_wdata[0];
  assign go         = ctrl_wr && reg_wdata[0];
  assign hs         = mem_req && mem_ready;
  assign desc_base  = {nda[AW-1:AB], {AB{1'b0}}};

  assign fetch_last = (fidx == F_END) || ((fidx == F_CMD) && !mem_rdata[XB]);
  assign fetch_done = (st == S_FETCH) && hs && !mem_err && fetch_last;
  assign wr_step    = (st == S_WRITE) && (!dwe || (hs && !mem_err));
  assign desc_end   = (fetch_done && (words_left == '0)) ||
                      (wr_step && (words_left == (AW-2)'(1)));
  assign cmd_now    = ((st == S_FETCH) && (fidx == F_CMD)) ? mem_rdata : cmd;

  assign mem_req   = (st == S_FETCH) || ((st == S_SRC) && rd_src) || ((st == S_WRITE) && dwe);
  assign mem_we    = (st == S_WRITE);
  assign mem_wdata = acc;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = desc_base + (AW'(fidx) << 2);
      S_SRC:   mem_addr = src[slot] + off;
      default: mem_addr = dst + off;
    endcase
  end

  always_comb begin
    case (reg_addr)
      R_CTRL:  reg_rdata = DW'(en);
      R_NDA:   reg_rdata = DW'(nda);
      R_STAT:  reg_rdata = DW'({f_abort, f_eot, f_eoc, busy});
      default: reg_rdata = '0;
    endcase
  end

  assign irq = f_eoc | f_eot | f_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      en <= 1'b0;
      f_eoc <= 1'b0;
      f_eot <= 1'b0;
      f_abort <= 1'b0;
      nda <= '0;
      nxt <= '0;
      dst <= '0;
      cnt <= '0;
      off <= '0;
      cmd <= '0;
      acc <= '0;
      fidx <= '0;
      slot <= '0;
      for (int i = 0; i < MAX_SRC; i++) src[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == R_STAT) begin
        f_eoc   <= f_eoc   & ~reg_wdata[1];
        f_eot   <= f_eot   & ~reg_wdata[2];
        f_abort <= f_abort & ~reg_wdata[3];
      end
      if (reg_wr && reg_addr == R_NDA && !busy) nda <= reg_wdata[AW-1:0];

      if (stop) begin
        st <= S_IDLE;
        en <= 1'b0;
      end else begin
        case (st)
          S_IDLE:
            if (go && nda != '0) begin
              st   <= S_FETCH;
              en   <= 1'b1;
              fidx <= '0;
            end
          S_FETCH:
            if (hs) begin
              if (mem_err) begin
                st <= S_IDLE;
                en <= 1'b0;
                f_abort <= 1'b1;
              end else begin
                if (fidx == '0) nxt <= mem_rdata[AW-1:0];
                else if (fidx >= F_S1 && fidx <= F_SH) src[SLW'(fidx - F_S1)] <= mem_rdata[AW-1:0];
                else if (fidx == F_DST) dst <= mem_rdata[AW-1:0];
                else if (fidx == F_CNT) cnt <= mem_rdata[AW-1:0];
                else if (fidx == F_CMD) cmd <= mem_rdata;
                else src[SLW'(fidx - F_XOFF)] <= mem_rdata[AW-1:0];
                fidx <= fidx + FIW'(1);
                if (fetch_last) begin
                  off  <= '0;
                  slot <= '0;
                  acc  <= '0;
                  st   <= S_SRC;
                end
              end
            end
          S_SRC:
            if (rd_src) begin
              if (hs) begin
                if (mem_err) begin
                  st <= S_IDLE;
                  en <= 1'b0;
                  f_abort <= 1'b1;
                end else begin
                  acc <= (code == C_LOAD) ? mem_rdata : (acc ^ mem_rdata);
                  if (slot == last_slot) st <= S_WRITE;
                  else slot <= slot + SLW'(1);
                end
              end
            end else begin
              if (code == C_IMM && slot == '0) acc <= DW'(src[0]);
              if (slot == last_slot) st <= S_WRITE;
              else slot <= slot + SLW'(1);
            end
          S_WRITE:
            if (dwe && hs && mem_err) begin
              st <= S_IDLE;
              en <= 1'b0;
              f_abort <= 1'b1;
            end else if (wr_step) begin
              cnt  <= cnt - AW'(4);
              off  <= off + AW'(4);
              slot <= '0;
              acc  <= '0;
              st   <= S_SRC;
            end
          default: st <= S_IDLE;
        endcase

        if (desc_end) begin
          if (cmd_now[IB]) begin
            if (nxt == '0) f_eoc <= 1'b1;
            else f_eot <= 1'b1;
          end
          if (nxt == '0) begin
            st <= S_IDLE;
            en <= 1'b0;
          end else begin
            nda  <= nxt;
            fidx <= '0;
            st   <= S_FETCH;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xor_chain_engine_chk.sv
module xor_chain_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          mem_err,
  input logic          busy,
  input logic          dwe,
  input logic          f_abort
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);
  assign stat_wr = reg_wr && (reg_addr == 2'd2);

  a_r13_hold_request: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready && !ctrl_wr |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r13_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r10_abort_halts: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && mem_err && !ctrl_wr |=> f_abort && !busy && !mem_req);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  a_r12_stop_halts: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !reg_wdata[0] |=> !busy);

  a_r7_write_needs_dwe: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> dwe);

  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !stat_wr |=> irq);
endmodule

bind xor_chain_engine xor_chain_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err),
  .busy(busy), .dwe(dwe), .f_abort(f_abort)
);

// File: tb/sim_xor_chain_engine.sv
`timescale 1ns/1ps
module sim_xor_chain_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        mem_err;

  logic [31:0] mem [0:1023];
  logic        stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          wcount = 0;
  int          total = 0, fails = 0;
  bit          finished = 0;

  localparam logic [31:0] GUARD = 32'hDEAD_BEEF;
  localparam int SBASE = 32'h200, SSTEP = 32'h40, DBASE = 32'h600;

  always #2 clk = ~clk;

  xor_chain_engine u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_err   = err_en && mem_req && (mem_addr == err_addr);

  always @(negedge clk) begin
    mem_ready <= mem_req && (!stall || lfsr[0]);
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk)
    if (mem_req && mem_ready && mem_we && !mem_err) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wcount <= wcount + 1;
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
  end

  function automatic logic [31:0] srcval(int i, int w, int seed);
    logic [31:0] t;
    t = 32'(i * 131 + w * 7 + seed * 1009 + 1);
    return (t * 32'h9E3779B9) ^ {i[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] mk_cmd(int n, bit dwe, bit ie);
    logic [31:0] c = '0;
    for (int i = 0; i < n; i++) c |= 32'((i == 0) ? 1 : 2) << (3 * i);
    if (n > 4) c[24] = 1'b1;
    c[25] = dwe;
    c[26] = ie;
    return c;
  endfunction

  function automatic logic [31:0] exp_xor(int n, int w, int seed);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v ^= srcval(i, w, seed);
    return v;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(int base, int nxt, int s0, int step, int dst, int cnt, logic [31:0] cmd);
    mem[base/4] = nxt;
    for (int i = 0; i < 4; i++) mem[base/4 + 1 + i] = s0 + i * step;
    mem[base/4 + 5] = dst;
    mem[base/4 + 6] = cnt;
    mem[base/4 + 7] = cmd;
    for (int i = 4; i < 8; i++) mem[base/4 + 4 + i] = s0 + i * step;
  endtask

  task automatic fill_src(int seed);
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 16; w++) mem[(SBASE + i * SSTEP)/4 + w] = srcval(i, w, seed);
  endtask

  task automatic clear_dst(int dst);
    for (int w = 0; w < 17; w++) mem[dst/4 + w] = GUARD;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int k = 0;
    do begin
      reg_read(2'd2, s);
      k++;
    end while (s[0] && k < 20000);
    chk(k < 20000, "R8 chain completes", 32'(k), 32'd20000);
  endtask

  task automatic run(int base);
    reg_write(2'd1, base);
    reg_write(2'd0, 32'd1);
    wait_idle();
  endtask

  task automatic check_xor(int dst, int n, int nw, int seed, string tag);
    int bad = 0;
    logic [31:0] a = '0, e = '0;
    for (int w = 0; w < nw; w++)
      if (mem[dst/4 + w] !== exp_xor(n, w, seed)) begin
        if (bad == 0) begin a = mem[dst/4 + w]; e = exp_xor(n, w, seed); end
        bad++;
      end
    chk(bad == 0, tag, a, e);
  endtask

  task automatic clear_status();
    logic [31:0] s;
    reg_read(2'd2, s);
    reg_write(2'd2, s);
  endtask

  initial begin
    logic [31:0] r;
    int wc;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    reg_read(2'd0, r); chk(r == 0, "R1 control after reset", r, 0);
    reg_read(2'd1, r); chk(r == 0, "R1 link register after reset", r, 0);
    reg_read(2'd2, r); chk(r == 0, "R1 status after reset", r, 0);
    chk(irq == 0 && mem_req == 0, "R1 irq and request idle", {irq, mem_req}, 0);

    reg_write(2'd1, 0);
    reg_write(2'd0, 1);
    reg_read(2'd2, r); chk(r == 0, "R2 zero address does not start", r, 0);
    reg_read(2'd0, r); chk(r == 0, "R2 enable stays clear", r, 0);

    for (int s = 0; s < 2; s++)
      for (int n = 1; n <= 8; n++) begin
        int nw = n + 2;
        stall = (s == 1);
        fill_src(n + 10 * s);
        clear_dst(DBASE);
        put_desc(32'h40, 0, SBASE, SSTEP, DBASE, nw * 4, mk_cmd(n, 1, 1));
        run(32'h40);
        check_xor(DBASE, n, nw, n + 10 * s,
                  s ? "R13 result under stalls" : (n > 4 ? "R4 extended sources used" : "R3 fold result"));
        chk(mem[DBASE/4 + nw] == GUARD, "R6 word after count untouched", mem[DBASE/4 + nw], GUARD);
        reg_read(2'd2, r); chk(r == 32'h2, "R9 end-of-chain flag only", r, 32'h2);
        chk(irq == 1, "R11 irq raised", irq, 1);
        clear_status();
        reg_read(2'd2, r); chk(r == 0 && irq == 0, "R11 write-back clears", {r[30:0], irq}, 0);
      end
    stall = 1'b0;

    fill_src(77);
    clear_dst(DBASE);
    begin
      logic [31:0] c = '0;
      c[2:0] = 3'd1;
      for (int i = 1; i < 8; i++) c[3*i +: 3] = 3'd2;
      c[25] = 1; c[26] = 1;
      put_desc(32'h40, 0, SBASE, SSTEP, DBASE, 24, c);
    end
    run(32'h40);
    check_xor(DBASE, 4, 6, 77, "R4 slots 5-8 ignored without extension bit");
    clear_status();

    clear_dst(DBASE);
    put_desc(32'h40, 0, 32'hA5A5_5A5A, 0, DBASE, 20, 32'h3 | (32'h1 << 25) | (32'h1 << 26));
    run(32'h40);
    begin
      int bad = 0;
      for (int w = 0; w < 5; w++) if (mem[DBASE/4 + w] != 32'hA5A5_5A5A) bad++;
      chk(bad == 0, "R5 immediate fill", 32'(bad), 0);
    end
    chk(mem[DBASE/4 + 5] == GUARD, "R6 fill stops at count", mem[DBASE/4 + 5], GUARD);
    clear_status();

    clear_dst(DBASE);
    put_desc(32'h40, 0, 0, 0, DBASE, 12, 32'h3 | (32'h1 << 25) | (32'h1 << 26));
    run(32'h40);
    chk(mem[DBASE/4] == 0 && mem[DBASE/4 + 2] == 0 && mem[DBASE/4 + 3] == GUARD,
        "R5 zero fill", mem[DBASE/4 + 2], 0);
    clear_status();

    clear_dst(DBASE);
    wc = wcount;
    put_desc(32'h40, 0, SBASE, SSTEP, DBASE, 0, mk_cmd(2, 1, 1));
    run(32'h40);
    chk(wcount == wc && mem[DBASE/4] == GUARD, "R6 zero count writes nothing", 32'(wcount - wc), 0);
    reg_read(2'd2, r); chk(r == 32'h2, "R6 zero count still completes", r, 32'h2);
    clear_status();

    fill_src(5);
    clear_dst(DBASE);
    wc = wcount;
    put_desc(32'h40, 0, SBASE, SSTEP, DBASE, 16, mk_cmd(3, 0, 1));
    run(32'h40);
    chk(wcount == wc && mem[DBASE/4] == GUARD, "R7 no write without enable bit", 32'(wcount - wc), 0);
    reg_read(2'd2, r); chk(r == 32'h2, "R7 descriptor completes", r, 32'h2);
    clear_status();

    fill_src(9);
    clear_dst(DBASE); clear_dst(DBASE + 32'h80); clear_dst(DBASE + 32'h100);
    put_desc(32'h40, 32'h80, SBASE, SSTEP, DBASE, 12, mk_cmd(1, 1, 1));
    put_desc(32'h80, 32'hC0, SBASE, SSTEP, DBASE + 32'h80, 16, mk_cmd(3, 1, 0));
    put_desc(32'hC0, 0, 32'h1234_5678, 0, DBASE + 32'h100, 8, 32'h3 | (32'h1 << 25) | (32'h1 << 26));
    reg_write(2'd1, 32'h40 | 32'h13);
    reg_read(2'd1, r); chk(r == 32'h53, "R2 link register holds written value", r, 32'h53);
    reg_write(2'd0, 1);
    reg_read(2'd2, r); chk(r[0] == 1, "R8 active while running", r, 1);
    wait_idle();
    check_xor(DBASE, 1, 3, 9, "R2 first descriptor fetched from aligned address");
    check_xor(DBASE + 32'h80, 3, 4, 9, "R8 second descriptor followed");
    chk(mem[(DBASE + 32'h100)/4 + 1] == 32'h1234_5678 && mem[(DBASE + 32'h100)/4 + 2] == GUARD,
        "R8 third descriptor followed", mem[(DBASE + 32'h100)/4 + 1], 32'h1234_5678);
    reg_read(2'd2, r); chk(r == 32'h6, "R9 transfer and chain flags", r, 32'h6);
    reg_read(2'd1, r); chk(r == 32'hC0, "R8 link register walked", r, 32'hC0);
    reg_write(2'd2, 32'h4);
    reg_read(2'd2, r); chk(r == 32'h2 && irq == 1, "R11 selective clear", r, 32'h2);
    clear_status();

    fill_src(21);
    clear_dst(DBASE);
    err_addr = SBASE + SSTEP + 4;
    err_en = 1'b1;
    put_desc(32'h40, 0, SBASE, SSTEP, DBASE, 16, mk_cmd(2, 1, 1));
    run(32'h40);
    reg_read(2'd2, r); chk(r == 32'h8, "R10 abort flag", r, 32'h8);
    reg_read(2'd0, r); chk(r == 0, "R10 enable cleared", r, 0);
    chk(mem[DBASE/4] == exp_xor(2, 0, 21) && mem[DBASE/4 + 1] == GUARD,
        "R10 transfer truncated at error", mem[DBASE/4 + 1], GUARD);
    chk(irq == 1, "R11 irq on abort", irq, 1);
    err_en = 1'b0;
    clear_status();

    stall = 1'b1;
    fill_src(33);
    clear_dst(DBASE);
    put_desc(32'h40, 0, SBASE, SSTEP, DBASE, 64, mk_cmd(8, 1, 1));
    reg_write(2'd1, 32'h40);
    reg_write(2'd0, 1);
    repeat (40) @(negedge clk);
    reg_write(2'd0, 0);
    reg_read(2'd2, r); chk(r == 0, "R12 stop clears active", r, 0);
    wc = wcount;
    repeat (60) @(negedge clk);
    chk(wcount == wc && mem_req == 0, "R12 no traffic after stop", 32'(wcount - wc), 0);
    chk(irq == 0, "R12 stop raises no flag", irq, 0);
    stall = 1'b0;

    summary();
  end
endmodule